// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the control and status core of a multi-source clock generator. The generator has an internal reference, an external crystal reference, a frequency-locked loop (FLL) and a phase-locked loop (PLL). Software programs two control registers through a small register port. One register chooses the output source, the reference and the reference divider code. The other chooses the loop, a low-power bypass flag, a range flag, an extra divide-by-32 flag and the VCO multiplier code. From these the block drives the clock mux select, the loop enables, the effective reference divisor and the effective multiplier.

Status flags live in a read-only register. They trail every accepted change by a fixed synchronisation delay, so software learns that a switch has taken effect only after it has. The PLL lock flag is qualified locally: it rises only after the external lock indication has held for a programmed number of cycles. It drops whenever the PLL is disabled or reconfigured. A request to hand the output clock to a loop is refused when that loop cannot deliver a clock. The loop configuration is frozen while a loop drives the output.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset, register 0 reads 0x04, register 1 reads 0x10 and register 2 reads 0x02. `clk_sel` is 00, `ref_div` is 1, `vco_mult` is 4, `pll_en` is 0 and `fll_en` is 1.
- R2: Register 0 holds the source request in bits [1:0], the reference-internal bit in bit 2 and the divider code in bits [5:3]. Register 1 holds loop-is-PLL in bit 0, low-power bypass in bit 1, high range in bit 2, extra divide-by-32 in bit 3 and the multiplier code in bits [7:4]. Both read back what was accepted.
- R3: `clk_sel` encodes the active source: 00 FLL, 01 internal reference, 10 external reference, 11 PLL. A request of 01 or 10 takes effect at the write edge.
- R4: A request of 00 (loop output) is refused when low-power bypass is set, or when the PLL is the selected loop and the lock flag is 0. A request of 11 is always refused. A refused write leaves the source field and `clk_sel` unchanged.
- R5: While `clk_sel` is 00 or 11, writes to register 1 have no effect.
- R6: With the FLL as loop, `ref_div` is 2^code. It is multiplied by 32 when both the high range and divide-by-32 bits are set (code 011 gives 256).
- R7: With the PLL as loop, `ref_div` is 2^code and the divide-by-32 bit is ignored (code 011 gives 8).
- R8: `vco_mult` is four times the multiplier code, and code 0 gives 4 (code 1000 gives 32).
- R9: `pll_en` is high only when the PLL is the loop and low-power bypass is clear. `fll_en` is high only when the FLL is the loop and bypass is clear.
- R10: Register 2 holds the oscillator-ready status in bit 0, the reference-internal status in bit 1, the clock status in bits [3:2] (same encoding as `clk_sel`) and PLL-active status in bit 4. These copy their sources exactly 4 edges after the write edge.
- R11: The lock flag in register 2 bit 5 rises 16 edges after the PLL becomes enabled with `pll_lock_in` high. It clears on the edge after `pll_lock_in` is low, after the PLL is disabled, or after a change of the divider code, loop select, bypass or multiplier.
- R12: The oscillator-ready status follows `osc_ready` through the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| osc_ready | input | 1 | Crystal oscillator started |
| pll_lock_in | input | 1 | Raw PLL lock indication |
| clk_sel | output | 2 | Active output clock source |
| ref_ext_sel | output | 1 | External reference selected |
| pll_en | output | 1 | PLL enable |
| fll_en | output | 1 | FLL enable |
| ref_div | output | 13 | Effective reference divisor |
| vco_mult | output | 6 | Effective PLL multiplier |

## Verification
Wrong stored configuration shows on `ref_div`, `vco_mult`, the enables and `clk_sel` at the edge after the write. Wrong acceptance logic shows as a `clk_sel` change after a refused request, or a register 1 readback change while a loop is active. A wrong status pipeline shows as register 2 changing one edge early or late around the fourth edge. A wrong lock counter shows as the lock bit off by a cycle around the sixteenth edge, or failing to drop on the edge after a lock glitch.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int RDIV_W  = 3;
    localparam int VMUL_W  = 4;
    localparam int HF_SHIFT = 5;
    localparam int DIV_W   = 1 + (2**RDIV_W - 1) + HF_SHIFT;
    localparam int MULT_W  = VMUL_W + 2;

    localparam logic [1:0] SEL_FLL = 2'b00;
    localparam logic [1:0] SEL_INT = 2'b01;
    localparam logic [1:0] SEL_EXT = 2'b10;
    localparam logic [1:0] SEL_PLL = 2'b11;

    typedef struct packed {
        logic [1:0]        osel;
        logic              rint;
        logic [RDIV_W-1:0] rdiv;
        logic              pll_sel;
        logic              lowpwr;
        logic              hirange;
        logic              xdiv32;
        logic [VMUL_W-1:0] vmul;
    } cfg_t;

    typedef struct packed {
        logic       osc;
        logic       rint;
        logic [1:0] src;
        logic       pll;
    } stat_t;

    localparam cfg_t CFG_RST = '{osel: SEL_FLL, rint: 1'b1, rdiv: '0,
                                 pll_sel: 1'b0, lowpwr: 1'b0, hirange: 1'b0,
                                 xdiv32: 1'b0, vmul: VMUL_W'(1)};

    localparam stat_t STAT_RST = '{osc: 1'b0, rint: 1'b1, src: SEL_FLL, pll: 1'b0};

    function automatic logic [1:0] active_src(input cfg_t c);
        if (c.osel == SEL_FLL) begin
            return c.pll_sel ? SEL_PLL : SEL_FLL;
        end
        return c.osel;
    endfunction

endpackage

// File: rtl/clkmode_regs.sv
module clkmode_regs
    import clkmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       lock_flag,
    output cfg_t       cfg,
    output logic       cfg_change
);

    typedef struct packed {
        cfg_t cfg;
    } regs_t;

    regs_t q, d;
    logic  chg;

    always_comb begin
        logic       loop_active;
        logic       accept;
        logic [1:0] req;
        d           = q;
        chg         = 1'b0;
        loop_active = (q.cfg.osel == SEL_FLL);
        req         = wdata[1:0];
        accept      = 1'b0;
        if (wr_en) begin
            case (addr)
                2'd0: begin
                    d.cfg.rint = wdata[2];
                    d.cfg.rdiv = wdata[3 +: RDIV_W];
                    case (req)
                        SEL_FLL: accept = !q.cfg.lowpwr && (!q.cfg.pll_sel || lock_flag);
                        SEL_INT: accept = 1'b1;
                        SEL_EXT: accept = 1'b1;
                        default: accept = 1'b0;
                    endcase
                    if (accept) begin
                        d.cfg.osel = req;
                    end
                    chg = (d.cfg.rdiv != q.cfg.rdiv);
                end
                2'd1: begin
                    if (!loop_active) begin
                        d.cfg.pll_sel = wdata[0];
                        d.cfg.lowpwr  = wdata[1];
                        d.cfg.hirange = wdata[2];
                        d.cfg.xdiv32  = wdata[3];
                        d.cfg.vmul    = wdata[4 +: VMUL_W];
                        chg = (d.cfg.pll_sel != q.cfg.pll_sel) ||
                              (d.cfg.lowpwr  != q.cfg.lowpwr)  ||
                              (d.cfg.vmul    != q.cfg.vmul);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cfg <= CFG_RST;
        end else begin
            q <= d;
        end
    end

    assign cfg        = q.cfg;
    assign cfg_change = chg;

endmodule

// File: rtl/clkmode_ratio.sv
module clkmode_ratio
    import clkmode_pkg::*;
(
    input  cfg_t              cfg,
    output logic [DIV_W-1:0]  ref_div,
    output logic [MULT_W-1:0] vco_mult
);

    localparam int SH_W = $clog2(DIV_W);

    logic [SH_W-1:0]   shift_d;
    logic [VMUL_W-1:0] code_eff;

    always_comb begin
        shift_d = SH_W'(cfg.rdiv);
        if (!cfg.pll_sel && cfg.hirange && cfg.xdiv32) begin
            shift_d = shift_d + SH_W'(HF_SHIFT);
        end
        ref_div  = DIV_W'(1) << shift_d;
        code_eff = (cfg.vmul == '0) ? VMUL_W'(1) : cfg.vmul;
        vco_mult = {code_eff, 2'b00};
    end

endmodule

// File: rtl/clkmode_sync.sv
module clkmode_sync
    import clkmode_pkg::*;
#(
    parameter int SYNC_CYC = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t stat_in,
    output stat_t stat_out
);

    stat_t stg_q [SYNC_CYC];
    stat_t stg_d [SYNC_CYC];

    always_comb begin
        stg_d[0] = stat_in;
        for (int i = 1; i < SYNC_CYC; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < SYNC_CYC; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q[g] <= STAT_RST;
                end else begin
                    stg_q[g] <= stg_d[g];
                end
            end
        end
    endgenerate

    assign stat_out = stg_q[SYNC_CYC-1];

endmodule

// File: rtl/clkmode_lock.sv
module clkmode_lock #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic lock_in,
    input  logic cfg_change,
    output logic lock_flag
);

    localparam int CNT_W = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lk_t;

    lk_t q, d;

    always_comb begin
        d = q;
        if (!pll_en || !lock_in || cfg_change) begin
            d.cnt = '0;
        end else if (q.cnt != CNT_W'(LOCK_CYC)) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign lock_flag = (q.cnt == CNT_W'(LOCK_CYC));

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int SYNC_CYC = 4,
    parameter int LOCK_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              osc_ready,
    input  logic              pll_lock_in,
    output logic [1:0]        clk_sel,
    output logic              ref_ext_sel,
    output logic              pll_en,
    output logic              fll_en,
    output logic [DIV_W-1:0]  ref_div,
    output logic [MULT_W-1:0] vco_mult
);

    cfg_t  cfg;
    logic  cfg_change;
    logic  lock_flag;
    stat_t stat_now;
    stat_t stat_seen;

    clkmode_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .lock_flag  (lock_flag),
        .cfg        (cfg),
        .cfg_change (cfg_change)
    );

    clkmode_ratio u_ratio (
        .cfg      (cfg),
        .ref_div  (ref_div),
        .vco_mult (vco_mult)
    );

    clkmode_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_en     (pll_en),
        .lock_in    (pll_lock_in),
        .cfg_change (cfg_change),
        .lock_flag  (lock_flag)
    );

    always_comb begin
        stat_now.osc  = osc_ready;
        stat_now.rint = cfg.rint;
        stat_now.src  = active_src(cfg);
        stat_now.pll  = cfg.pll_sel && !cfg.lowpwr;
    end

    clkmode_sync #(.SYNC_CYC(SYNC_CYC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_in  (stat_now),
        .stat_out (stat_seen)
    );

    assign clk_sel     = active_src(cfg);
    assign ref_ext_sel = !cfg.rint;
    assign pll_en      = cfg.pll_sel && !cfg.lowpwr;
    assign fll_en      = !cfg.pll_sel && !cfg.lowpwr;

    always_comb begin
        case (addr)
            2'd0:    rdata = {2'b00, cfg.rdiv, cfg.rint, cfg.osel};
            2'd1:    rdata = {cfg.vmul, cfg.xdiv32, cfg.hirange, cfg.lowpwr, cfg.pll_sel};
            2'd2:    rdata = {2'b00, lock_flag, stat_seen.pll, stat_seen.src,
                              stat_seen.rint, stat_seen.osc};
            default: rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk
    import clkmode_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        clk_sel,
    input logic              pll_en,
    input logic              fll_en,
    input logic              pll_lock_in,
    input logic              lock_flag,
    input logic [DIV_W-1:0]  ref_div,
    input logic [MULT_W-1:0] vco_mult
);

    // R9
    loop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_en && fll_en));

    // R11
    lock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |=> !lock_flag);

    // R11
    lock_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock_in |=> !lock_flag);

    // R4
    pll_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SEL_PLL && $past(clk_sel) != SEL_PLL) |-> $past(lock_flag));

    // R5
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SEL_FLL || clk_sel == SEL_PLL) |=> ($stable(vco_mult) && $stable(pll_en)));

    // R6
    div_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ref_div) == 1);

endmodule

bind clkmode_ctrl clkmode_chk u_chk (.*);

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        osc_ready = 1'b0;
    logic        pll_lock_in = 1'b0;
    logic [1:0]  clk_sel;
    logic        ref_ext_sel;
    logic        pll_en;
    logic        fll_en;
    logic [12:0] ref_div;
    logic [5:0]  vco_mult;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        logic [15:0] mask;
        string       req;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    clkmode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .osc_ready(osc_ready), .pll_lock_in(pll_lock_in),
        .clk_sel(clk_sel), .ref_ext_sel(ref_ext_sel), .pll_en(pll_en),
        .fll_en(fll_en), .ref_div(ref_div), .vco_mult(vco_mult)
    );

    // monitor: compare queued expectations half a cycle later
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = {8'h00, rdata};
                1: act = {14'd0, clk_sel};
                2: act = {3'd0, ref_div};
                3: act = {10'd0, vco_mult};
                default: act = {14'd0, pll_en, fll_en};
            endcase
            applied++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind,
                         act & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // observes state after the latest edge, then advances one edge
    task automatic chk(input int kind, input logic [1:0] a, input logic [15:0] exp,
                       input logic [15:0] mask, input string req);
        item_t it;
        addr = a;
        it.kind = kind; it.exp = exp; it.mask = mask; it.req = req;
        sb.push_back(it);
        @(negedge clk);
        #1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(0, 2'd0, 16'h04, 16'hFF, "R1");
        chk(0, 2'd1, 16'h10, 16'hFF, "R1");
        chk(0, 2'd2, 16'h02, 16'hFF, "R1");
        chk(1, 2'd0, 16'd0, 16'hFFFF, "R1");
        chk(2, 2'd0, 16'd1, 16'hFFFF, "R1");
        chk(3, 2'd0, 16'd4, 16'hFFFF, "R1");
        chk(4, 2'd0, 16'b01, 16'hFFFF, "R1");
        pll_lock_in = 1'b1;
        // R5 loop active after reset: register 1 write dropped
        wr(2'd1, 8'hFF);
        chk(0, 2'd1, 16'h10, 16'hFF, "R5");
        chk(4, 2'd0, 16'b01, 16'hFFFF, "R5");
        // R12 oscillator status
        osc_ready = 1'b1;
        chk(0, 2'd2, 16'h00, 16'h01, "R12");
        idle(6);
        chk(0, 2'd2, 16'h01, 16'h01, "R12");
        // R3 external reference, R2 readback, R10 status delay
        wr(2'd0, 8'h1A);
        chk(1, 2'd0, 16'b10, 16'hFFFF, "R3");
        chk(0, 2'd0, 16'h1A, 16'hFF, "R2");
        idle(1);
        chk(0, 2'd2, 16'h03, 16'hFF, "R10");
        chk(0, 2'd2, 16'h09, 16'hFF, "R10");
        chk(2, 2'd0, 16'd8, 16'hFFFF, "R6");
        // R6 high range with divide-by-32
        wr(2'd1, 8'h1C);
        chk(2, 2'd0, 16'd256, 16'hFFFF, "R6");
        chk(3, 2'd0, 16'd4, 16'hFFFF, "R8");
        chk(0, 2'd1, 16'h1C, 16'hFF, "R2");
        // PLL prepared under low-power bypass
        wr(2'd1, 8'h8F);
        chk(2, 2'd0, 16'd8, 16'hFFFF, "R7");
        chk(3, 2'd0, 16'd32, 16'hFFFF, "R8");
        chk(4, 2'd0, 16'b00, 16'hFFFF, "R9");
        idle(5);
        chk(0, 2'd2, 16'h00, 16'h30, "R9");
        // R4 loop request refused while bypassed
        wr(2'd0, 8'h18);
        chk(1, 2'd0, 16'b10, 16'hFFFF, "R4");
        chk(0, 2'd0, 16'h1A, 16'hFF, "R4");
        // leave bypass: PLL enabled, status and lock follow
        wr(2'd1, 8'h8D);
        chk(4, 2'd0, 16'b10, 16'hFFFF, "R9");
        idle(2);
        chk(0, 2'd2, 16'h00, 16'h10, "R10");
        chk(0, 2'd2, 16'h10, 16'h10, "R10");
        idle(10);
        chk(0, 2'd2, 16'h00, 16'h20, "R11");
        chk(0, 2'd2, 16'h20, 16'h20, "R11");
        // R11 lock glitch restarts qualification
        pll_lock_in = 1'b0;
        idle(1);
        pll_lock_in = 1'b1;
        chk(0, 2'd2, 16'h00, 16'h20, "R11");
        idle(14);
        chk(0, 2'd2, 16'h00, 16'h20, "R11");
        chk(0, 2'd2, 16'h20, 16'h20, "R11");
        // R4 loop request accepted once locked
        wr(2'd0, 8'h18);
        chk(1, 2'd0, 16'b11, 16'hFFFF, "R4");
        idle(3);
        chk(0, 2'd2, 16'h3D, 16'hFF, "R10");
        chk(0, 2'd0, 16'h18, 16'hFF, "R2");
        // R5 configuration frozen while PLL drives the output
        wr(2'd1, 8'h00);
        chk(0, 2'd1, 16'h8D, 16'hFF, "R5");
        chk(4, 2'd0, 16'b10, 16'hFFFF, "R5");
        chk(0, 2'd2, 16'h20, 16'h20, "R5");
        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

endmodule